// File: doc/BRIEF.md
# Linestate End-of-Packet Detector with SE0 Glitch Filter

This block watches the two-bit linestate that a USB PHY presents on its UTMI or ULPI side and reports the end of a full-speed or low-speed packet as a one-cycle pulse. An end of packet is an SE0 (both data lines low) followed by the idle J state. J and K swap places between full-speed and low-speed signalling, and the block accounts for that.

The D+ and D- paths through the PHY can arrive with a few nanoseconds of skew. That skew can make the linestate show SE0 for a single clock while a packet is still going out. If that false SE0 were taken as the end of the packet, the controller would start its next packet while the PHY is still sending the current one.

An enable input turns on a filter against this glitch. While the filter is in force, SE0 must be sampled on two consecutive PHY clock edges before it counts. The filter is in force only when the controller is transmitting, and only in these cases:
- in host mode, at either full speed or low speed;
- in device mode, at full speed, during the link-power-management handshake transmit.

In every other case, a single SE0 sample is enough.

Top module: `ls_eop_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, `eop_pulse` is low after that edge. Any SE0 run counted before reset is discarded, so J seen right after reset produces no pulse.
- R2: With the filter not in force, one SE0 sample (`line_st` = 00) followed by J raises `eop_pulse` in the cycle after the edge that samples J.
- R3: With the filter in force (`glitch_filt_en`=1, `tx_busy`=1, `host_role`=1), a single-sample SE0 followed by J produces no pulse.
- R4: With the filter in force, two consecutive SE0 samples followed by J raise `eop_pulse` in the cycle after the edge that samples J.
- R5: At full speed (`low_speed`=0), J is 01 and K is 10. At low speed (`low_speed`=1), J is 10 and K is 01. In host mode the filter applies at low speed as it does at full speed.
- R6: In device mode (`host_role`=0), the filter is in force only when `low_speed`=0 and `lpm_hs`=1. Otherwise a single SE0 sample is enough.
- R7: While `tx_busy`=0 (receive), a single SE0 sample followed by J gives a pulse, even with `glitch_filt_en`=1.
- R8: `eop_pulse` is never high on two consecutive cycles.
- R9: An SE0 run broken by K before its second sample restarts the count. With the filter in force, SE0, K, SE0, J gives no pulse.
- R10: At the first edge that samples `tx_busy` low after it was high, no pulse is produced and any partly counted SE0 run is cleared.
- R11: A pulse follows only J. SE1 (11) or K after a qualified SE0 run gives no pulse, and it clears the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_st | input | 2 | Raw linestate: 00 SE0, 11 SE1, 01/10 J or K depending on speed |
| tx_busy | input | 1 | Controller is transmitting a packet |
| glitch_filt_en | input | 1 | Enables the SE0 glitch filter |
| host_role | input | 1 | 1 = host mode, 0 = device mode |
| low_speed | input | 1 | 1 = low-speed port, 0 = full-speed port |
| lpm_hs | input | 1 | Device is transmitting the link-power-management handshake |
| eop_pulse | output | 1 | One-cycle end-of-packet indication |

## Verification
The hardest case to reach is the clock edge at which transmit ends while a one-sample SE0 is still pending. At that edge the receive rule would accept the single sample, so only the run-clearing behaviour keeps the pulse away. The stimulus table places a transmit SE0 directly before a row that drops `tx_busy` and presents J, with the filter both on and off. The other filter-sensitive cases also sit in adjacent rows of the table: the device-mode variants and the SE0 runs broken by K or SE1.

// File: rtl/eop_filt_pkg.sv
// Package eop_filt_pkg
// Shared symbol type for the linestate EOP detector, plus the mapping from
// the raw two-bit linestate to bus symbols.
// Assumes: 00 = SE0, 11 = SE1; the 01/10 codes swap J and K at low speed.
package eop_filt_pkg;

    typedef enum logic [1:0] {
        SYM_SE0 = 2'd0,
        SYM_J   = 2'd1,
        SYM_K   = 2'd2,
        SYM_SE1 = 2'd3
    } line_sym_t;

    // Map a raw linestate sample to a bus symbol for the given speed.
    function automatic line_sym_t map_line(input logic [1:0] raw, input logic slow);
        line_sym_t s;
        case (raw)
            2'b00:   s = SYM_SE0;
            2'b01:   s = slow ? SYM_K : SYM_J;
            2'b10:   s = slow ? SYM_J : SYM_K;
            default: s = SYM_SE1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ls_line_decode.sv
// Module ls_line_decode
// Turns the raw PHY linestate into a bus symbol (SE0, J, K or SE1), taking
// the port speed into account. Purely combinational.
// Assumes: the linestate is already synchronous to clk.
module ls_line_decode
    import eop_filt_pkg::*;
(
    input  logic [1:0] line_raw,
    input  logic       slow,
    output line_sym_t  sym
);

    // Decode the symbol for the current sample.
    always_comb begin
        sym = map_line(line_raw, slow);
    end

endmodule

// File: rtl/ls_filter_qual.sv
// Module ls_filter_qual
// Works out how many consecutive SE0 samples make a valid EOP in the
// current cycle. The multi-sample rule is in force only while transmitting
// with the filter enabled, in host mode (any speed) or in device mode at
// full speed during the LPM handshake. Otherwise one sample is enough.
// Assumes: the mode inputs are steady for the length of a packet.
module ls_filter_qual #(
    parameter int FILT_SAMPLES = 2,
    localparam int CW = $clog2(FILT_SAMPLES + 1)
) (
    input  logic          filt_en,
    input  logic          tx_busy,
    input  logic          host_role,
    input  logic          slow,
    input  logic          lpm_hs,
    output logic [CW-1:0] need_cnt
);

    logic role_ok;
    logic filt_on;

    // Decide whether the role and speed allow filtering.
    always_comb begin
        role_ok = host_role | (~slow & lpm_hs);
    end

    // Pick the SE0 run length required in this cycle.
    always_comb begin
        filt_on  = filt_en & tx_busy & role_ok;
        need_cnt = filt_on ? CW'(FILT_SAMPLES) : CW'(1);
    end

endmodule

// File: rtl/ls_se0_run.sv
// Module ls_se0_run
// Counts consecutive SE0 symbols, saturating at FILT_SAMPLES. When J
// follows a long enough run, it issues a registered one-cycle EOP pulse.
// K and SE1 clear the run. A falling edge of tx_busy clears the run and
// suppresses the pulse for that edge.
// Assumes: need_cnt is at least 1 and at most FILT_SAMPLES.
module ls_se0_run
    import eop_filt_pkg::*;
#(
    parameter int FILT_SAMPLES = 2,
    localparam int CW = $clog2(FILT_SAMPLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  line_sym_t     sym,
    input  logic          tx_busy,
    input  logic [CW-1:0] need_cnt,
    output logic          eop_pulse
);

    localparam logic [CW-1:0] RUN_MAX = CW'(FILT_SAMPLES);

    logic [CW-1:0] run_cnt;
    logic          tx_q;
    logic          tx_fall;

    // Detect the cycle in which transmit activity ends.
    always_comb begin
        tx_fall = tx_q & ~tx_busy;
    end

    // Register transmit activity for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= 1'b0;
        end else begin
            tx_q <= tx_busy;
        end
    end

    // Track the SE0 run and issue the EOP pulse on the following J.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            eop_pulse <= 1'b0;
        end else begin
            eop_pulse <= 1'b0;
            if (tx_fall) begin
                run_cnt <= '0;
            end else begin
                unique case (sym)
                    SYM_SE0: begin
                        if (run_cnt != RUN_MAX) begin
                            run_cnt <= run_cnt + CW'(1);
                        end
                    end
                    SYM_J: begin
                        if (run_cnt != '0 && run_cnt >= need_cnt) begin
                            eop_pulse <= 1'b1;
                        end
                        run_cnt <= '0;
                    end
                    default: begin
                        run_cnt <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/ls_eop_detect.sv
// Module ls_eop_detect
// Top level of the linestate EOP detector. It joins the symbol decoder,
// the filter qualification and the SE0 run tracker.
// Assumes: all inputs are synchronous to the PHY interface clock.
module ls_eop_detect
    import eop_filt_pkg::*;
#(
    parameter int FILT_SAMPLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_st,
    input  logic       tx_busy,
    input  logic       glitch_filt_en,
    input  logic       host_role,
    input  logic       low_speed,
    input  logic       lpm_hs,
    output logic       eop_pulse
);

    localparam int CW = $clog2(FILT_SAMPLES + 1);

    line_sym_t     sym;
    logic [CW-1:0] need_cnt;

    ls_line_decode u_decode (
        .line_raw (line_st),
        .slow     (low_speed),
        .sym      (sym)
    );

    ls_filter_qual #(.FILT_SAMPLES(FILT_SAMPLES)) u_qual (
        .filt_en   (glitch_filt_en),
        .tx_busy   (tx_busy),
        .host_role (host_role),
        .slow      (low_speed),
        .lpm_hs    (lpm_hs),
        .need_cnt  (need_cnt)
    );

    ls_se0_run #(.FILT_SAMPLES(FILT_SAMPLES)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym       (sym),
        .tx_busy   (tx_busy),
        .need_cnt  (need_cnt),
        .eop_pulse (eop_pulse)
    );

endmodule

// File: rtl/eop_filt_checker.sv
// Module eop_filt_checker
// Port-level properties of ls_eop_detect. Bound into the top module below.
// Assumes: the default two-sample filter length.
module eop_filt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] line_st,
    input logic       tx_busy,
    input logic       glitch_filt_en,
    input logic       host_role,
    input logic       low_speed,
    input logic       lpm_hs,
    input logic       eop_pulse
);

    // R1: reset forces the pulse low.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !eop_pulse);

    // R8: the pulse lasts a single cycle.
    p_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pulse |=> !eop_pulse);

    // R11: a pulse follows only J, decoded for the speed then in use.
    p_idle_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pulse |-> ($past(line_st) == ($past(low_speed) ? 2'b10 : 2'b01)));

    // R2: an SE0 sample came just before the J.
    p_se0_before_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pulse |-> ($past(line_st, 2) == 2'b00));

    // R4: while the filter is in force, the sample before that was SE0 too.
    p_two_samples_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_pulse && $past(glitch_filt_en && tx_busy &&
                            (host_role || (!low_speed && lpm_hs))))
        |-> ($past(line_st, 3) == 2'b00));

    // R10: no pulse at the edge where transmit ends.
    p_tx_fall_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tx_busy) && !tx_busy) |=> !eop_pulse);

endmodule

bind ls_eop_detect eop_filt_checker u_chk (.*);

// File: tb/ls_eop_detect_test.sv
`timescale 1ns/1ps
module ls_eop_detect_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line_st = 2'b01;
    logic       tx_busy = 1'b0;
    logic       glitch_filt_en = 1'b0;
    logic       host_role = 1'b1;
    logic       low_speed = 1'b0;
    logic       lpm_hs = 1'b0;
    logic       eop_pulse;

    int  checks = 0;
    int  errors = 0;
    bit  run_done = 1'b0;

    always #2.5 clk = ~clk;

    ls_eop_detect uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_st        (line_st),
        .tx_busy        (tx_busy),
        .glitch_filt_en (glitch_filt_en),
        .host_role      (host_role),
        .low_speed      (low_speed),
        .lpm_hs         (lpm_hs),
        .eop_pulse      (eop_pulse)
    );

    // Vector: [11:8] requirement, [7:3] en,host,ls,lpm,tx, [2:1] line, [0] expected pulse
    localparam int NV = 53;
    localparam logic [11:0] VEC [NV] = '{
        {4'd2,  5'b01001, 2'b01, 1'b0},   // R2 idle
        {4'd2,  5'b01001, 2'b00, 1'b0},   // R2 one SE0
        {4'd2,  5'b01001, 2'b01, 1'b1},   // R2 EOP, filter off
        {4'd8,  5'b01001, 2'b01, 1'b0},   // R8 pulse ends
        {4'd3,  5'b11001, 2'b00, 1'b0},   // R3 glitch
        {4'd3,  5'b11001, 2'b01, 1'b0},   // R3 rejected
        {4'd3,  5'b11001, 2'b01, 1'b0},
        {4'd4,  5'b11001, 2'b00, 1'b0},   // R4 first SE0
        {4'd4,  5'b11001, 2'b00, 1'b0},   // R4 second SE0
        {4'd4,  5'b11001, 2'b01, 1'b1},   // R4 EOP
        {4'd8,  5'b11001, 2'b01, 1'b0},   // R8
        {4'd5,  5'b11101, 2'b00, 1'b0},   // R5 LS glitch
        {4'd5,  5'b11101, 2'b10, 1'b0},   // R5 LS J rejected
        {4'd5,  5'b11101, 2'b00, 1'b0},
        {4'd5,  5'b11101, 2'b00, 1'b0},
        {4'd5,  5'b11101, 2'b10, 1'b1},   // R5 LS EOP
        {4'd8,  5'b11101, 2'b10, 1'b0},   // R8
        {4'd5,  5'b11101, 2'b00, 1'b0},
        {4'd5,  5'b11101, 2'b00, 1'b0},
        {4'd11, 5'b11101, 2'b01, 1'b0},   // R11 01 is K at LS
        {4'd6,  5'b10001, 2'b00, 1'b0},   // R6 device FS, no LPM
        {4'd6,  5'b10001, 2'b01, 1'b1},   // R6 unfiltered EOP
        {4'd6,  5'b10011, 2'b01, 1'b0},   // R6 device FS LPM
        {4'd6,  5'b10011, 2'b00, 1'b0},
        {4'd6,  5'b10011, 2'b01, 1'b0},   // R6 filtered glitch
        {4'd6,  5'b10011, 2'b00, 1'b0},
        {4'd6,  5'b10011, 2'b00, 1'b0},
        {4'd6,  5'b10011, 2'b01, 1'b1},   // R6 filtered EOP
        {4'd6,  5'b10111, 2'b10, 1'b0},   // R6 device LS LPM
        {4'd6,  5'b10111, 2'b00, 1'b0},
        {4'd6,  5'b10111, 2'b10, 1'b1},   // R6 LS device unfiltered
        {4'd7,  5'b11000, 2'b01, 1'b0},   // R7 receive
        {4'd7,  5'b11000, 2'b00, 1'b0},
        {4'd7,  5'b11000, 2'b01, 1'b1},   // R7 single SE0 in receive
        {4'd9,  5'b11001, 2'b01, 1'b0},   // R9
        {4'd9,  5'b11001, 2'b00, 1'b0},
        {4'd9,  5'b11001, 2'b10, 1'b0},   // R9 K breaks run
        {4'd9,  5'b11001, 2'b00, 1'b0},
        {4'd9,  5'b11001, 2'b01, 1'b0},   // R9 no EOP
        {4'd11, 5'b11001, 2'b00, 1'b0},
        {4'd11, 5'b11001, 2'b00, 1'b0},
        {4'd11, 5'b11001, 2'b11, 1'b0},   // R11 SE1
        {4'd11, 5'b11001, 2'b01, 1'b0},   // R11 cleared
        {4'd11, 5'b11001, 2'b00, 1'b0},
        {4'd11, 5'b11001, 2'b00, 1'b0},
        {4'd11, 5'b11001, 2'b10, 1'b0},   // R11 K
        {4'd11, 5'b11001, 2'b01, 1'b0},   // R11 cleared
        {4'd10, 5'b11001, 2'b00, 1'b0},   // R10 partial run
        {4'd10, 5'b11000, 2'b01, 1'b0},   // R10 tx falls
        {4'd10, 5'b01001, 2'b00, 1'b0},   // R10 filter off
        {4'd10, 5'b01000, 2'b01, 1'b0},   // R10 tx falls
        {4'd7,  5'b01000, 2'b00, 1'b0},
        {4'd7,  5'b01000, 2'b01, 1'b1}    // R7
    };

    task automatic check(input int req, input logic exp, input int idx);
        checks++;
        if (eop_pulse !== exp) begin
            errors++;
            $display("FAIL R%0d step %0d: eop_pulse=%0b expected %0b", req, idx, eop_pulse, exp);
        end
    endtask

    task automatic step(input logic [11:0] v, input int idx);
        @(negedge clk);
        {glitch_filt_en, host_role, low_speed, lpm_hs, tx_busy} = v[7:3];
        line_st = v[2:1];
        @(posedge clk);
        #1;
        check(int'(v[11:8]), v[0], idx);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1, 1'b0, -1);                           // R1 reset state
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i], i);
        end
        // R1: reset discards a pending SE0 run
        step({4'd1, 5'b01001, 2'b00, 1'b0}, 100);
        @(negedge clk);
        rst_n = 1'b0;
        line_st = 2'b01;
        @(posedge clk);
        #1;
        check(1, 1'b0, 101);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(1, 1'b0, 102);
        step({4'd2, 5'b01001, 2'b00, 1'b0}, 103);
        step({4'd2, 5'b01001, 2'b01, 1'b1}, 104);     // R2 after reset
        run_done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!run_done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run_done=0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule